// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block passes short messages between an application processor and an I/O co-processor. It holds two independent message queues. The outbound queue carries traffic from the application side to the I/O side. The return queue carries traffic in the opposite direction. Each message is a 64-bit lead word plus a 32-bit tail word. Both processors reach the same register window, each through its own register port. Every port has a valid strobe, a write flag, an 8-bit byte address, 64-bit write data and 64-bit read data.

A sender first writes the lead word, which is only staged. It then writes the tail word, and that write pushes the pair into the queue. A receiver reads the lead word, then reads the tail word. Reading the tail word pops the entry. The tail-word read also returns occupancy and pointer fields in its upper half. Four interrupt causes record whether each queue has been empty or non-empty since software last cleared them. The causes are masked by an enable register and drive two level-sensitive interrupt lines.

The register ports have no back-pressure. An access is taken in every cycle in which valid is high, and read data is returned in that same cycle. A full queue is reported through status bits and not by stalling the port: a push into a full queue is dropped and the drop is recorded. The queue depth is a parameter and must be a power of two.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, so each queue's control word reads 0x2_0000. The interrupt enable reads 0, and both interrupt lines are low.
- R2: A write of the lead word alone does not push anything. A write of the tail word (bits 31:0 of the write data) pushes the {staged lead, tail} pair. Entries leave in the order they arrived: the lead word reads at queue base + 0x20 and the tail word at base + 0x28. The outbound queue has its base at 0x50 and the return queue at 0x80. The lead is sent at base + 0x10 and the tail at base + 0x18.
- R3: A push into a full queue is dropped and does not change the stored entries. It sets a sticky overflow flag at bit 18 of that queue's control word, which only reset clears.
- R4: A pop from an empty queue returns zero in the message bits (lead word, and tail bits 31:0) and leaves the queue's pointers and count unchanged.
- R5: Only the application port can stage or push into the outbound queue, and only the I/O port can pop it. For the return queue the roles are reversed. A send from the wrong port has no effect, and a read of the tail word from the wrong port returns the data without popping.
- R6: In each queue's control word, bit 16 reads 1 exactly when the queue holds DEPTH entries, and bit 17 reads 1 exactly when it holds none.
- R7: The tail-word read carries status in its upper bits:
  - bits 56:52 hold the entry count;
  - bits 51:48 hold the free-slot count, low 4 bits;
  - bits 47:44 hold the read pointer;
  - bits 43:40 hold the write pointer;
  - bits 63:57 and 39:32 read as zero.
  All of these are the values before the read takes effect.
- R8: Cause register 0x4C has four bits:
  - bit 0: outbound queue empty;
  - bit 1: outbound queue non-empty;
  - bit 2: return queue empty;
  - bit 3: return queue non-empty.
  A cause latches on the clock edge after its condition holds and stays set until a 1 is written to that bit of 0x4C. If the condition still holds at the acknowledge, the cause stays set.
- R9: Enable register 0x48 (bits 3:0) masks the causes. irq_recv_nonempty is the OR of the enabled causes 1 and 3. irq_send_empty is the OR of the enabled causes 0 and 2.
- R10: A push and a pop of the same queue in the same cycle both take effect when the queue is neither full nor empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| app_valid | input | 1 | Application port access strobe |
| app_write | input | 1 | Application port: 1 write, 0 read |
| app_addr | input | 8 | Application port byte address |
| app_wdata | input | 64 | Application port write data |
| app_rdata | output | 64 | Application port read data, same cycle |
| io_valid | input | 1 | I/O port access strobe |
| io_write | input | 1 | I/O port: 1 write, 0 read |
| io_addr | input | 8 | I/O port byte address |
| io_wdata | input | 64 | I/O port write data |
| io_rdata | output | 64 | I/O port read data, same cycle |
| irq_recv_nonempty | output | 1 | Level interrupt for enabled non-empty causes |
| irq_send_empty | output | 1 | Level interrupt for enabled empty causes |

## Verification
The hardest situation to reach is one queue being pushed by one port and popped by the other in the very same cycle. The bench reaches it by staging a lead word first, then driving the tail write on the application port and the tail read on the I/O port in one cycle. A second hard case is the overflow path, which needs the whole depth filled before the extra push. The bench fills the queue, then drains it, and checks that the dropped message never appears. The re-latch on acknowledge is reached by clearing a non-empty cause while a message is still waiting.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 64;
  localparam int TAIL_W = 32;
  localparam int MSG_W  = DATA_W + TAIL_W;
  localparam int NCAUSE = 4;
  localparam int NDIR   = 2;

  localparam logic [ADDR_W-1:0] ADR_IRQ_EN  = 8'h48;
  localparam logic [ADDR_W-1:0] ADR_IRQ_ACK = 8'h4C;
  // offsets from a queue's control word
  localparam logic [ADDR_W-1:0] OFS_SEND_LEAD = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SEND_TAIL = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RECV_LEAD = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RECV_TAIL = 8'h28;

  // cause bits: 0 out-empty, 1 out-nonempty, 2 ret-empty, 3 ret-nonempty
  localparam logic [NCAUSE-1:0] RECV_MASK = 4'b1010;
  localparam logic [NCAUSE-1:0] SEND_MASK = 4'b0101;

  function automatic logic [ADDR_W-1:0] dir_base(input int d);
    return (d == 0) ? 8'h50 : 8'h80;
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 96,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic [AW:0]   count,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr
);
  logic [W-1:0] mem [DEPTH];
  logic do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (push && full) overflow <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |=> overflow && $stable(wr_ptr)); // R3
  AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty |=> $stable(rd_ptr)); // R4
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH)); // R6
  AST_PUSH_POP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !full && !empty |=> $stable(count)); // R10
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int N = 4,
  parameter logic [N-1:0] RMASK = '0,
  parameter logic [N-1:0] SMASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] ack,
  output logic [N-1:0] en_q,
  output logic [N-1:0] cause_q,
  output logic         irq_recv,
  output logic         irq_send
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      cause_q <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      cause_q <= (cause_q & ~ack) | cond;
    end
  end

  assign irq_recv = |(cause_q & en_q & RMASK);
  assign irq_send = |(cause_q & en_q & SMASK);

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cause_q) & ~$past(ack) & ~cause_q) == {N{1'b0}})); // R8
  AST_COND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cond) & ~cause_q) == {N{1'b0}})); // R8
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox import mbox_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_valid,
  input  logic              app_write,
  input  logic [ADDR_W-1:0] app_addr,
  input  logic [DATA_W-1:0] app_wdata,
  output logic [DATA_W-1:0] app_rdata,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              irq_recv_nonempty,
  output logic              irq_send_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int NP = 2; // port 0 application, port 1 I/O
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [NP-1:0]             p_vld, p_wr;
  logic [NP-1:0][ADDR_W-1:0] p_addr;
  logic [NP-1:0][DATA_W-1:0] p_wdata;

  assign p_vld   = {io_valid, app_valid};
  assign p_wr    = {io_write, app_write};
  assign p_addr  = {io_addr, app_addr};
  assign p_wdata = {io_wdata, app_wdata};

  logic [NDIR-1:0]             push, pop, full, empty, ovf;
  logic [NDIR-1:0][MSG_W-1:0]  head;
  logic [NDIR-1:0][AW:0]       cnt;
  logic [NDIR-1:0][AW-1:0]     rdp, wrp;
  logic [NDIR-1:0][DATA_W-1:0] ctrl, stat;

  // queue d is filled by port d and drained by port 1-d (R5)
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam logic [ADDR_W-1:0] BASE = dir_base(d);
    localparam int SRC = d;
    localparam int SNK = 1 - d;
    logic [DATA_W-1:0] stage_q;
    logic [AW:0]       free_n;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else if (p_vld[SRC] && p_wr[SRC] && p_addr[SRC] == BASE + OFS_SEND_LEAD)
        stage_q <= p_wdata[SRC];
    end

    assign push[d] = p_vld[SRC] & p_wr[SRC] & (p_addr[SRC] == BASE + OFS_SEND_TAIL);
    assign pop[d]  = p_vld[SNK] & ~p_wr[SNK] & (p_addr[SNK] == BASE + OFS_RECV_TAIL);

    mbox_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push[d]),
      .push_data({stage_q, p_wdata[SRC][TAIL_W-1:0]}),
      .pop      (pop[d]),
      .head     (head[d]),
      .full     (full[d]),
      .empty    (empty[d]),
      .overflow (ovf[d]),
      .count    (cnt[d]),
      .rd_ptr   (rdp[d]),
      .wr_ptr   (wrp[d])
    );

    assign free_n  = DEPTH_V - cnt[d];
    assign ctrl[d] = {45'b0, ovf[d], empty[d], full[d], 16'b0};
    assign stat[d] = {7'b0, 5'(cnt[d]), 4'(free_n), 4'(rdp[d]), 4'(wrp[d]),
                      8'b0, head[d][TAIL_W-1:0]};
  end

  // interrupt enable / acknowledge decode; application port wins enable writes
  logic [NP-1:0]      en_hit, ack_hit;
  logic [NCAUSE-1:0]  en_q, cause_q, ack_bits, cond;
  for (genvar p = 0; p < NP; p++) begin : g_hit
    assign en_hit[p]  = p_vld[p] & p_wr[p] & (p_addr[p] == ADR_IRQ_EN);
    assign ack_hit[p] = p_vld[p] & p_wr[p] & (p_addr[p] == ADR_IRQ_ACK);
  end
  assign ack_bits = ({NCAUSE{ack_hit[0]}} & p_wdata[0][NCAUSE-1:0])
                  | ({NCAUSE{ack_hit[1]}} & p_wdata[1][NCAUSE-1:0]);
  assign cond = {~empty[1], empty[1], ~empty[0], empty[0]};

  mbox_irq #(.N(NCAUSE), .RMASK(RECV_MASK), .SMASK(SEND_MASK)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (cond),
    .en_we   (|en_hit),
    .en_wdata(en_hit[0] ? p_wdata[0][NCAUSE-1:0] : p_wdata[1][NCAUSE-1:0]),
    .ack     (ack_bits),
    .en_q    (en_q),
    .cause_q (cause_q),
    .irq_recv(irq_recv_nonempty),
    .irq_send(irq_send_empty)
  );

  // same-cycle read mux per port
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [DATA_W-1:0] rd;
    always_comb begin
      rd = '0;
      if (p_vld[p] && !p_wr[p]) begin
        if (p_addr[p] == ADR_IRQ_EN)  rd = DATA_W'(en_q);
        if (p_addr[p] == ADR_IRQ_ACK) rd = DATA_W'(cause_q);
        for (int d = 0; d < NDIR; d++) begin
          if (p_addr[p] == dir_base(d))                 rd = ctrl[d];
          if (p_addr[p] == dir_base(d) + OFS_RECV_LEAD) rd = head[d][MSG_W-1:TAIL_W];
          if (p_addr[p] == dir_base(d) + OFS_RECV_TAIL) rd = stat[d];
        end
      end
    end
  end

  assign app_rdata = g_port[0].rd;
  assign io_rdata  = g_port[1].rd;
endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  localparam real CLK_NS = 8.0;
  localparam int  DEPTH  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic app_valid = 0, app_write = 0, io_valid = 0, io_write = 0;
  logic [7:0]  app_addr = 0, io_addr = 0;
  logic [63:0] app_wdata = 0, io_wdata = 0;
  logic [63:0] app_rdata, io_rdata;
  logic irq_recv_nonempty, irq_send_empty;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  ipc_mailbox #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .app_valid(app_valid), .app_write(app_write), .app_addr(app_addr),
    .app_wdata(app_wdata), .app_rdata(app_rdata),
    .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .irq_recv_nonempty(irq_recv_nonempty), .irq_send_empty(irq_send_empty)
  );

  typedef struct packed {
    logic        side;   // 0 application, 1 I/O
    logic        wr;
    logic [7:0]  addr;
    logic [63:0] data;
    logic        chk;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{0, 1, 8'h60, 64'h1111_2222_3333_4444, 0, 64'h0, 4'd2},               // R2 stage lead
    '{1, 0, 8'h50, 64'h0, 1, 64'h2_0000, 4'd2},                            // R2 lead alone: still empty
    '{0, 1, 8'h68, 64'hFFFF_0000_AAAA_0001, 0, 64'h0, 4'd2},
    '{0, 1, 8'h60, 64'h5555_6666_7777_8888, 0, 64'h0, 4'd2},
    '{0, 1, 8'h68, 64'h0000_0000_BBBB_0002, 0, 64'h0, 4'd2},
    '{1, 0, 8'h50, 64'h0, 1, 64'h0, 4'd6},                                 // R6 neither flag
    '{1, 0, 8'h70, 64'h0, 1, 64'h1111_2222_3333_4444, 4'd2},
    '{1, 0, 8'h78, 64'h0, 1, 64'h002E_0200_AAAA_0001, 4'd7},               // R7 cnt2 free14 rd0 wr2
    '{1, 0, 8'h70, 64'h0, 1, 64'h5555_6666_7777_8888, 4'd2},
    '{1, 0, 8'h78, 64'h0, 1, 64'h001F_1200_BBBB_0002, 4'd7},               // R7 cnt1 free15 rd1 wr2
    '{1, 0, 8'h50, 64'h0, 1, 64'h2_0000, 4'd6},
    '{0, 1, 8'h90, 64'hCAFE, 0, 64'h0, 4'd5},                              // R5 wrong port send
    '{0, 1, 8'h98, 64'h1, 0, 64'h0, 4'd5},
    '{1, 0, 8'h80, 64'h0, 1, 64'h2_0000, 4'd5},
    '{1, 1, 8'h60, 64'hCAFE, 0, 64'h0, 4'd5},
    '{1, 1, 8'h68, 64'h1, 0, 64'h0, 4'd5},
    '{1, 0, 8'h50, 64'h0, 1, 64'h2_0000, 4'd5},
    '{1, 1, 8'h90, 64'hDEAD_BEEF_0000_0001, 0, 64'h0, 4'd2},
    '{1, 1, 8'h98, 64'h1234_5678, 0, 64'h0, 4'd2},
    '{1, 0, 8'h98 + 8'h10, 64'h0, 1, 64'h001F_0100_1234_5678, 4'd5},       // R5 wrong-port tail read
    '{0, 0, 8'hA0, 64'h0, 1, 64'hDEAD_BEEF_0000_0001, 4'd2},
    '{0, 0, 8'hA8, 64'h0, 1, 64'h001F_0100_1234_5678, 4'd5},               // R5 no earlier pop
    '{0, 0, 8'h80, 64'h0, 1, 64'h2_0000, 4'd6}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic side, input logic wr, input logic [7:0] addr,
                        input logic [63:0] wdata, output logic [63:0] rdata);
    @(negedge clk);
    if (!side) begin
      app_valid = 1; app_write = wr; app_addr = addr; app_wdata = wdata;
    end else begin
      io_valid = 1; io_write = wr; io_addr = addr; io_wdata = wdata;
    end
    #1;
    rdata = side ? io_rdata : app_rdata;
    @(posedge clk);
    #1;
    app_valid = 0; io_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [63:0] io_rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    access(0, 0, 8'h50, 0, rd); chk("R1 outbound ctrl", rd, 64'h2_0000);
    access(0, 0, 8'h80, 0, rd); chk("R1 return ctrl", rd, 64'h2_0000);
    access(0, 0, 8'h48, 0, rd); chk("R1 enable", rd, 64'h0);
    chk("R1 irq lines", {62'b0, irq_recv_nonempty, irq_send_empty}, 64'h0);
    idle(2);
    access(1, 0, 8'h4C, 0, rd); chk("R8 empty causes after reset", rd, 64'h5);

    // table walk
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].side, VEC[i].wr, VEC[i].addr, VEC[i].data, rd);
      if (VEC[i].chk) chk($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
    end

    // R8 sticky then acknowledge
    idle(2);
    access(0, 0, 8'h4C, 0, rd); chk("R8 all causes sticky", rd, 64'hF);
    access(0, 1, 8'h4C, 64'hF, rd);
    idle(2);
    access(0, 0, 8'h4C, 0, rd); chk("R8 ack clears nonempty causes only", rd, 64'h5);

    // R9 enable masking
    access(0, 1, 8'h48, 64'hA, rd);
    access(1, 0, 8'h48, 0, rd); chk("R9 enable readback", rd, 64'hA);
    chk("R9 lines low with no pending enabled cause",
        {62'b0, irq_recv_nonempty, irq_send_empty}, 64'h0);
    access(1, 1, 8'h90, 64'h4242, rd);
    access(1, 1, 8'h98, 64'h77, rd);
    idle(2);
    chk("R9 recv line on return nonempty", {62'b0, irq_recv_nonempty, irq_send_empty}, 64'h2);
    access(0, 1, 8'h48, 64'h1, rd);
    chk("R9 send line on outbound empty", {62'b0, irq_recv_nonempty, irq_send_empty}, 64'h1);

    // R8 re-latch when acknowledged while condition holds
    access(0, 1, 8'h4C, 64'h8, rd);
    idle(1);
    access(0, 0, 8'h4C, 0, rd); chk("R8 re-latch on held condition", rd, 64'hD);
    access(0, 0, 8'hA8, 0, rd); chk("R7 return status cnt1 rd1 wr2", rd, 64'h001F_1200_0000_0077);
    access(0, 1, 8'h4C, 64'h8, rd);
    idle(1);
    access(0, 0, 8'h4C, 0, rd); chk("R8 cleared after drain", rd, 64'h5);

    // R3 / R6 overflow
    for (int i = 0; i < DEPTH; i++) begin
      access(0, 1, 8'h60, 64'h100 + 64'(i), rd);
      access(0, 1, 8'h68, 64'(i), rd);
    end
    access(1, 0, 8'h50, 0, rd); chk("R6 full flag", rd, 64'h1_0000);
    access(0, 1, 8'h60, 64'hBAD, rd);
    access(0, 1, 8'h68, 64'hBAD, rd);
    access(1, 0, 8'h50, 0, rd); chk("R3 overflow flag", rd, 64'h5_0000);
    for (int i = 0; i < DEPTH; i++) begin
      access(1, 0, 8'h70, 0, rd); chk("R3 lead order kept", rd, 64'h100 + 64'(i));
      access(1, 0, 8'h78, 0, rd);
      if (i == 0) chk("R7 full status cnt16 rd2 wr2", rd, 64'h0100_2200_0000_0000);
      else chk("R3 tail order kept", {32'b0, rd[31:0]}, 64'(i));
    end
    access(1, 0, 8'h50, 0, rd); chk("R3 overflow sticky, R6 empty", rd, 64'h6_0000);

    // R4 pop from empty
    access(1, 0, 8'h70, 0, rd); chk("R4 empty lead zero", rd, 64'h0);
    access(1, 0, 8'h78, 0, rd); chk("R4 empty tail status only", rd, 64'h0000_2200_0000_0000);
    access(1, 0, 8'h78, 0, rd); chk("R4 pointers unchanged", rd, 64'h0000_2200_0000_0000);

    // R10 same-cycle push and pop
    access(0, 1, 8'h60, 64'hAAAA, rd);
    access(0, 1, 8'h68, 64'h11, rd);
    access(0, 1, 8'h60, 64'hBBBB, rd);
    @(negedge clk);
    app_valid = 1; app_write = 1; app_addr = 8'h68; app_wdata = 64'h22;
    io_valid = 1; io_write = 0; io_addr = 8'h78; io_wdata = 0;
    #1 io_rd = io_rdata;
    @(posedge clk);
    #1 app_valid = 0; io_valid = 0;
    chk("R10 pop sees first entry", io_rd, 64'h001F_2300_0000_0011);
    access(1, 0, 8'h50, 0, rd); chk("R10 one entry left", rd, 64'h4_0000);
    access(1, 0, 8'h70, 0, rd); chk("R10 second lead", rd, 64'hBBBB);
    access(1, 0, 8'h78, 0, rd); chk("R10 second tail status", rd, 64'h001F_3400_0000_0022);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule